// File: doc/BRIEF.md
# Debug halt and single-step controller

This block is a small memory-mapped control unit through which an external debugger stops a processor core, advances it by one instruction at a time and lets it run again. A debugger reaches it through a simple register port: an address, write data, a write enable, combinational read data and a ready flag. Toward the core it drives a halt request and a step permit. From the core it takes a halted level and a one-cycle instruction-retired pulse. It also exports the value of the write-only register selector, so that the core's register-transfer path can use it.

A step works like this. The core is halted with debug enabled. Software arms the step bit and then clears the halt bit. The step permit stays high until one retired pulse arrives. The block then sets the halt bit again by itself, so the core halts after exactly one instruction. Clearing the enable bit ends halting debug and the core runs freely. An asynchronous power-on reset clears every register. A system reset, or a vector-reset request, clears only the halt bit and the four event-catch bits of the monitor control register.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While power-on reset is asserted, `ready`, `halt_req` and `step_ok` are 0. After reset, every register reads 0, `xfer_sel` is 0, and `ready` is 1 from the first clock edge onward.
- R2: The control word sits at offset 0xF0. Its writable bits are 0 (enable), 1 (halt), 2 (step), 3 and 5. Bit 4 and bits 6 to 31, apart from the status bit, read 0. A write updates it only when wdata[31:16] equals 0xA05F; any other write leaves it unchanged.
- R3: `halt_req` is 1 exactly when the enable bit and the halt bit are both 1. A halt bit set with enable clear has no effect.
- R4: Status bit 17 of the control word reads 1 one edge after `core_halted` rises while enable is set. It reads 0 in the same cycle that `core_halted` is low.
- R5: `step_ok` is 1 while enable and step are set and halt is clear. A retired pulse sampled while `step_ok` is 1 sets the halt bit. After that edge, `halt_req` is 1 and `step_ok` is 0.
- R6: While the enable bit is 0, both `halt_req` and `step_ok` are 0.
- R7: A system reset (`sys_rst_n` low) or a vector-reset request (`vec_rst` high), sampled at an edge, clears control bit 1 and monitor bits 19 to 16 and leaves every other bit unchanged. It takes priority over a write in the same cycle.
- R8: The selector at 0xF4 is write-only. It stores wdata[SEL_W-1:0], drives `xfer_sel`, and reads as 0. The data register at 0xF8 stores and returns all 32 bits.
- R9: The monitor control register at 0xFC stores and returns all 32 bits.
- R10: Writes to any other offset change nothing, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, sampled, active low |
| vec_rst | input | 1 | Vector-reset request, sampled, active high |
| addr | input | AW | Register byte offset |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write enable |
| rdata | output | 32 | Read data for `addr` |
| ready | output | 1 | Access complete (high after reset) |
| halt_req | output | 1 | Halt request to the core |
| step_ok | output | 1 | Permission to retire one instruction |
| xfer_sel | output | SEL_W | Register selector value for the core |
| core_halted | input | 1 | Core reports it is stopped |
| instr_retired | input | 1 | One-cycle pulse per retired instruction |

## Verification
The bench goes after the write key first. A design that skips the key check would let a keyless write start halting. The halt bit is set while enable is clear; a design that ignores enable would stop the core. The bench also runs one complete step, checking that `step_ok` drops and `halt_req` returns on the edge that samples the retired pulse; a wrong design would let the core run on or never re-halt. The partial resets are checked to clear only the halt bit and the monitor's catch nibble; a design that wipes the whole register would lose the debugger's enable and data.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFS_CTL = 8'hF0;
  localparam logic [7:0] OFS_SEL = 8'hF4;
  localparam logic [7:0] OFS_DAT = 8'hF8;
  localparam logic [7:0] OFS_MON = 8'hFC;

  localparam logic [15:0] WR_KEY = 16'hA05F;

  localparam int unsigned CTL_W   = 6;
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_HALT  = 1;
  localparam int unsigned B_STEP  = 2;
  localparam int unsigned B_MASK  = 3;
  localparam int unsigned B_STALL = 5;
  localparam int unsigned B_STAT  = 17;

  localparam logic [CTL_W-1:0] CTL_WMASK =
    CTL_W'((1 << B_EN) | (1 << B_HALT) | (1 << B_STEP) | (1 << B_MASK) | (1 << B_STALL));

  localparam int unsigned MON_CLR_LO = 16;
  localparam int unsigned MON_CLR_HI = 19;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_CTL  = 3'd1,
    RS_SEL  = 3'd2,
    RS_DAT  = 3'd3,
    RS_MON  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/dbg_addr_dec.sv
module dbg_addr_dec
  import dbg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    if (addr == AW'(OFS_CTL))      sel = RS_CTL;
    else if (addr == AW'(OFS_SEL)) sel = RS_SEL;
    else if (addr == AW'(OFS_DAT)) sel = RS_DAT;
    else if (addr == AW'(OFS_MON)) sel = RS_MON;
    else                           sel = RS_NONE;
  end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             vec_rst,
  input  logic             wr,
  input  logic [15:0]      key,
  input  logic [CTL_W-1:0] wbits,
  input  logic             hw_set_halt,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_d;
  logic             key_ok;
  logic             part_rst;
  logic             ctl_ce;

  assign key_ok   = (key == WR_KEY);
  assign part_rst = !sys_rst_n || vec_rst;
  assign ctl_ce   = (wr && key_ok) || hw_set_halt || part_rst;

  always_comb begin
    ctl_d = ctl_q;
    if (wr && key_ok) ctl_d = wbits & CTL_WMASK;
    if (hw_set_halt)  ctl_d[B_HALT] = 1'b1;
    if (part_rst)     ctl_d[B_HALT] = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  input  logic halt,
  input  logic step,
  input  logic core_halted,
  input  logic instr_retired,
  output logic halt_req,
  output logic step_ok,
  output logic hw_set_halt,
  output logic status
);
  logic stat_q;
  logic stat_d;

  assign halt_req    = en && halt;
  assign step_ok     = en && step && !halt;
  assign hw_set_halt = step_ok && instr_retired;

  assign stat_d = core_halted && en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q && core_halted && en;
endmodule

// File: rtl/dbg_aux_regs.sv
module dbg_aux_regs
  import dbg_pkg::*;
#(
  parameter int unsigned SEL_W = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             vec_rst,
  input  logic             wr_sel,
  input  logic             wr_dat,
  input  logic             wr_mon,
  input  logic [DW-1:0]    wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic [DW-1:0]    dat_q,
  output logic [DW-1:0]    mon_q
);
  logic [DW-1:0] mon_d;
  logic          part_rst;
  logic          mon_ce;

  assign part_rst = !sys_rst_n || vec_rst;
  assign mon_ce   = wr_mon || part_rst;

  always_comb begin
    mon_d = mon_q;
    if (wr_mon)   mon_d = wdata;
    if (part_rst) mon_d[MON_CLR_HI:MON_CLR_LO] = '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      dat_q <= '0;
    else if (wr_dat) dat_q <= wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      mon_q <= '0;
    else if (mon_ce) mon_q <= mon_d;
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned SEL_W = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             vec_rst,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  input  logic             wen,
  output logic [31:0]      rdata,
  output logic             ready,
  output logic             halt_req,
  output logic             step_ok,
  output logic [SEL_W-1:0] xfer_sel,
  input  logic             core_halted,
  input  logic             instr_retired
);
  localparam int unsigned CTL_PAD_HI = B_STAT - CTL_W;
  localparam int unsigned CTL_PAD_LO = DW - B_STAT - 1;

  reg_sel_e         sel;
  logic [CTL_W-1:0] ctl_q;
  logic             hw_set_halt;
  logic             status;
  logic [DW-1:0]    dat_q;
  logic [DW-1:0]    mon_q;
  logic             ready_q;

  dbg_addr_dec #(.AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  dbg_ctl_reg u_ctl (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .vec_rst     (vec_rst),
    .wr          (wen && (sel == RS_CTL)),
    .key         (wdata[31:16]),
    .wbits       (wdata[CTL_W-1:0]),
    .hw_set_halt (hw_set_halt),
    .ctl_q       (ctl_q)
  );

  dbg_step_seq u_seq (
    .clk           (clk),
    .por_n         (por_n),
    .en            (ctl_q[B_EN]),
    .halt          (ctl_q[B_HALT]),
    .step          (ctl_q[B_STEP]),
    .core_halted   (core_halted),
    .instr_retired (instr_retired),
    .halt_req      (halt_req),
    .step_ok       (step_ok),
    .hw_set_halt   (hw_set_halt),
    .status        (status)
  );

  dbg_aux_regs #(.SEL_W(SEL_W)) u_aux (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .vec_rst   (vec_rst),
    .wr_sel    (wen && (sel == RS_SEL)),
    .wr_dat    (wen && (sel == RS_DAT)),
    .wr_mon    (wen && (sel == RS_MON)),
    .wdata     (wdata),
    .sel_q     (xfer_sel),
    .dat_q     (dat_q),
    .mon_q     (mon_q)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign ready = ready_q;

  always_comb begin
    unique case (sel)
      RS_CTL:  rdata = {{CTL_PAD_LO{1'b0}}, status, {CTL_PAD_HI{1'b0}}, ctl_q};
      RS_DAT:  rdata = dat_q;
      RS_MON:  rdata = mon_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
  import dbg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             vec_rst,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic             wen,
  input logic [31:0]      rdata,
  input logic             halt_req,
  input logic             step_ok,
  input logic             core_halted,
  input logic             instr_retired,
  input logic [CTL_W-1:0] ctl_bits,
  input logic [31:0]      mon_bits
);
  logic at_ctl;
  logic unmapped;
  assign at_ctl   = (addr == AW'(OFS_CTL));
  assign unmapped = !at_ctl && (addr != AW'(OFS_SEL)) &&
                    (addr != AW'(OFS_DAT)) && (addr != AW'(OFS_MON));

  assert_keyless_write_ignored_R2: assert property (@(posedge clk) disable iff (!por_n)
    (wen && at_ctl && (wdata[31:16] != WR_KEY) && sys_rst_n && !vec_rst &&
     !(step_ok && instr_retired)) |=> $stable(ctl_bits));

  assert_status_follows_core_R4: assert property (@(posedge clk) disable iff (!por_n)
    (at_ctl && !core_halted) |-> !rdata[B_STAT]);

  assert_step_rehalts_R5: assert property (@(posedge clk) disable iff (!por_n)
    (step_ok && instr_retired && !wen && sys_rst_n && !vec_rst) |=> (halt_req && !step_ok));

  assert_disabled_is_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
    !ctl_bits[B_EN] |-> (!halt_req && !step_ok));

  assert_partial_reset_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n || vec_rst) |=> (!ctl_bits[B_HALT] && (mon_bits[MON_CLR_HI:MON_CLR_LO] == 4'h0)));

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
    unmapped |-> (rdata == 32'h0));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .sys_rst_n     (sys_rst_n),
  .vec_rst       (vec_rst),
  .addr          (addr),
  .wdata         (wdata),
  .wen           (wen),
  .rdata         (rdata),
  .halt_req      (halt_req),
  .step_ok       (step_ok),
  .core_halted   (core_halted),
  .instr_retired (instr_retired),
  .ctl_bits      (ctl_q),
  .mon_bits      (mon_q)
);

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;
  localparam int AW    = 8;
  localparam int SEL_W = 7;
  localparam int NVEC  = 15;

  typedef struct packed {
    logic        wen;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        ch;
    logic        ret;
    logic [31:0] exp_rd;
    logic        exp_hr;
    logic        exp_so;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 8'hF0, 32'h0000_0003, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'd2},  // R2 no key
    '{1'b1, 8'hF0, 32'hA05F_0002, 1'b0, 1'b0, 32'h0000_0002, 1'b0, 1'b0, 4'd3},  // R3 halt w/o enable
    '{1'b1, 8'hF0, 32'hA05F_0003, 1'b0, 1'b0, 32'h0000_0003, 1'b1, 1'b0, 4'd3},  // R3 halt
    '{1'b0, 8'hF0, 32'h0000_0000, 1'b1, 1'b0, 32'h0002_0003, 1'b1, 1'b0, 4'd4},  // R4 status set
    '{1'b1, 8'hF0, 32'hA05F_0005, 1'b1, 1'b0, 32'h0002_0005, 1'b0, 1'b1, 4'd5},  // R5 arm+release
    '{1'b0, 8'hF0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0005, 1'b0, 1'b1, 4'd4},  // R4 status clear
    '{1'b0, 8'hF0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0007, 1'b1, 1'b0, 4'd5},  // R5 retire
    '{1'b0, 8'hF0, 32'h0000_0000, 1'b1, 1'b0, 32'h0002_0007, 1'b1, 1'b0, 4'd5},  // R5 re-halted
    '{1'b1, 8'hF0, 32'hA05F_0006, 1'b1, 1'b0, 32'h0000_0006, 1'b0, 1'b0, 4'd6},  // R6 exit
    '{1'b1, 8'hF0, 32'hA05F_FFFF, 1'b0, 1'b0, 32'h0000_002F, 1'b1, 1'b0, 4'd2},  // R2 mask
    '{1'b1, 8'hF8, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'd8},  // R8 data
    '{1'b1, 8'hF4, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd8},  // R8 selector
    '{1'b1, 8'hFC, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd9},  // R9 monitor
    '{1'b1, 8'hEC, 32'h1234_5678, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd10}, // R10 unmapped
    '{1'b0, 8'hF8, 32'h0000_0000, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'd10}  // R10 no side effect
  };

  logic             clk = 1'b0;
  logic             por_n, sys_rst_n, vec_rst;
  logic [AW-1:0]    addr;
  logic [31:0]      wdata;
  logic             wen;
  logic [31:0]      rdata;
  logic             ready, halt_req, step_ok;
  logic [SEL_W-1:0] xfer_sel;
  logic             core_halted, instr_retired;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl #(.AW(AW), .SEL_W(SEL_W)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .vec_rst(vec_rst),
    .addr(addr), .wdata(wdata), .wen(wen), .rdata(rdata), .ready(ready),
    .halt_req(halt_req), .step_ok(step_ok), .xfer_sel(xfer_sel),
    .core_halted(core_halted), .instr_retired(instr_retired)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; addr = a; wdata = d;
    cyc();
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wen = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b1; vec_rst = 1'b0;
    addr = 8'hF0; wdata = '0; wen = 1'b0;
    core_halted = 1'b0; instr_retired = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", {31'b0, ready}, 32'h0);
    @(negedge clk);
    por_n = 1'b1;
    cyc();
    chk("R1 ready after reset", {31'b0, ready}, 32'h1);
    chk("R1 ctl reset value", rdata, 32'h0);
    chk("R1 halt_req reset", {31'b0, halt_req}, 32'h0);
    chk("R1 step_ok reset", {31'b0, step_ok}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wen = TBL[i].wen; addr = TBL[i].addr; wdata = TBL[i].wdata;
      core_halted = TBL[i].ch; instr_retired = TBL[i].ret;
      cyc();
      chk($sformatf("R%0d vec%0d rdata", TBL[i].req, i), rdata, TBL[i].exp_rd);
      chk($sformatf("R%0d vec%0d halt_req", TBL[i].req, i), {31'b0, halt_req}, {31'b0, TBL[i].exp_hr});
      chk($sformatf("R%0d vec%0d step_ok", TBL[i].req, i), {31'b0, step_ok}, {31'b0, TBL[i].exp_so});
      chk("R1 ready stays high", {31'b0, ready}, 32'h1);
    end
    @(negedge clk);
    wen = 1'b0; core_halted = 1'b0; instr_retired = 1'b0;
    chk("R8 xfer_sel holds selector", {25'b0, xfer_sel}, 32'h7F);

    // R7: system reset clears only halt bit and monitor 19:16
    @(negedge clk);
    sys_rst_n = 1'b0; addr = 8'hF0;
    cyc();
    @(negedge clk);
    sys_rst_n = 1'b1;
    #1;
    chk("R7 sysrst ctl", rdata, 32'h0000_002D);
    chk("R7 sysrst halt_req", {31'b0, halt_req}, 32'h0);
    rd_chk(8'hFC, 32'hFFF0_FFFF, "R7 sysrst monitor");
    rd_chk(8'hF8, 32'hDEAD_BEEF, "R7 sysrst data kept");

    // R7: vector reset wins over a same-cycle write
    wr(8'hF0, 32'hA05F_0003);
    wr(8'hFC, 32'hFFFF_FFFF);
    @(negedge clk);
    vec_rst = 1'b1; wen = 1'b1; addr = 8'hF0; wdata = 32'hA05F_0003;
    cyc();
    @(negedge clk);
    vec_rst = 1'b0; wen = 1'b0;
    #1;
    chk("R7 vecrst ctl", rdata, 32'h0000_0001);
    rd_chk(8'hFC, 32'hFFF0_FFFF, "R7 vecrst monitor");

    // R6: leaving debug while a step is armed withdraws the permit
    wr(8'hF0, 32'hA05F_0005);
    chk("R5 step_ok armed", {31'b0, step_ok}, 32'h1);
    wr(8'hF0, 32'hA05F_0004);
    chk("R6 step_ok after exit", {31'b0, step_ok}, 32'h0);
    chk("R6 halt_req after exit", {31'b0, halt_req}, 32'h0);

    // R1: power-on reset clears everything
    wr(8'hF0, 32'hA05F_0003);
    chk("R3 halt_req before por", {31'b0, halt_req}, 32'h1);
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R1 por halt_req", {31'b0, halt_req}, 32'h0);
    chk("R1 por ready", {31'b0, ready}, 32'h0);
    @(negedge clk);
    por_n = 1'b1;
    cyc();
    chk("R1 por ready back", {31'b0, ready}, 32'h1);
    rd_chk(8'hF0, 32'h0, "R1 por ctl");
    rd_chk(8'hF8, 32'h0, "R1 por data");
    rd_chk(8'hFC, 32'h0, "R1 por monitor");
    chk("R1 por xfer_sel", {25'b0, xfer_sel}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule